// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending Queue

This block records the first uncorrectable error a function reports. It keeps the uncorrectable status bits, a pointer to the bit of the error that is currently logged, the four header dwords of that error and, when allowed, its four prefix dwords. Each report arrives as one record request. The request carries a one-hot status vector, the header and prefix dwords, a flag that says the header is valid and a flag that says a prefix is present.

When multiple-header recording is switched on and the logged error is still outstanding, later reports wait in a FIFO of parameterised depth. A report that finds the FIFO full is dropped, and a one-cycle overflow pulse goes out. The reporting logic turns that pulse into a correctable header-log-overflow error.

Software clears status bits with write-1-to-clear operations. When the logged error's bit is cleared, the oldest waiting report moves into the log. Clears that leave the logged error in place cannot remove the bits of waiting reports.

Top module: `hdr_log_queue`

## Requirements
- R1: After reset, the status bits, the first-error pointer, the prefix-present flag, both logs and the overflow output are all zero. `multi_cap` is 1 whenever DEPTH is greater than 0.
- R2: A record request that is not queued sets its status bit, loads the pointer with the index of the lowest set bit of `rec_status`, and loads the header log. All of these are visible on the clock edge that samples the request.
- R3: A logged report whose header-valid flag is 0 leaves all four header-log dwords at zero.
- R4: The prefix log and `prefix_logged` are loaded only when the report's prefix-present flag and `prefix_en` are both 1. Otherwise both are zero.
- R5: With `multi_en` at 1 and the status bit at the first-error pointer set, a new report is queued. The log stays unchanged and the report's status bit is still set.
- R6: A report that would be queued while DEPTH reports are already waiting is discarded. `log_overflow` is then 1 for exactly one cycle, and the status bit is still set.
- R7: A clear that removes the first-error bit while reports are waiting (with `multi_en` at 1) moves the oldest report into the log. The status bits of every report that was waiting, the moved one included, are then set again.
- R8: A clear that removes the first-error bit with no report waiting, or with `multi_en` at 0, zeroes the pointer, `prefix_logged` and both logs.
- R9: A clear that leaves the first-error bit set, with `multi_en` at 1, restores the bits of waiting reports. Other bits named in the mask stay cleared.
- R10: Any clear made while `multi_en` is 0 discards all waiting reports.
- R11: When a record request and a clear arrive in the same cycle, the clear is ignored.
- R12: With `multi_en` at 0, every report overwrites the log and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| multi_en | input | 1 | Multiple-header recording enable |
| prefix_en | input | 1 | End-to-end prefix logging enable |
| rec_valid | input | 1 | Record request strobe |
| rec_status | input | STAT_W | One-hot status bit of the report |
| rec_hdr_valid | input | 1 | Header dwords of the report are valid |
| rec_prefix_present | input | 1 | Prefix dwords of the report are present |
| rec_hdr | input | NDW*DW_W | Header dwords, dword 0 in the low bits |
| rec_prefix | input | NDW*DW_W | Prefix dwords, dword 0 in the low bits |
| clr_valid | input | 1 | Write-1-to-clear strobe on the status bits |
| clr_mask | input | STAT_W | Bits to clear |
| unc_status | output | STAT_W | Uncorrectable status bits |
| first_ptr | output | $clog2(STAT_W) | First-error pointer |
| prefix_logged | output | 1 | Prefix log holds valid data |
| hdr_log | output | NDW*DW_W | Header log |
| prefix_log | output | NDW*DW_W | Prefix log |
| log_overflow | output | 1 | One-cycle pulse when a report is dropped |
| multi_cap | output | 1 | Multiple-header recording is available |

## Verification
Every result of a record or clear request shows up on the clock edge that samples the request. This covers the status bits, the pointer, the logs, the prefix flag and the overflow pulse. The driver sets the inputs at a falling edge and updates a reference model of the requirements. It then pushes the expected output image after the next rising edge, and the monitor compares that image at the following falling edge. The overflow pulse is checked to drop again on an idle cycle that comes after it.

// File: rtl/hlq_pkg.sv
package hlq_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_LOG,
    ACT_QUEUE,
    ACT_DROP,
    ACT_PROMOTE,
    ACT_WIPE,
    ACT_RESTORE,
    ACT_FLUSH
  } hlq_act_e;
endpackage

// File: rtl/hlq_entry_fifo.sv
module hlq_entry_fifo #(
  parameter int DEPTH  = 4,
  parameter int EW     = 263,
  parameter int IDXW   = 5,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [EW-1:0]     push_data,
  input  logic [IDXW-1:0]   push_idx,
  output logic              full,
  output logic              empty,
  output logic [EW-1:0]     head,
  output logic [STAT_W-1:0] pend
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0]   mem   [DEPTH];
  logic [IDXW-1:0] idx_q [DEPTH];
  logic [PW-1:0]   rd_q, wr_q;
  logic [CW-1:0]   cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_q]   <= push_data;
      idx_q[wr_q] <= push_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (pop && !push) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign head  = mem[rd_q];

  always_comb begin
    pend = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (((i - int'(rd_q) + DEPTH) % DEPTH) < int'(cnt_q))
        pend[idx_q[i]] = 1'b1;
    end
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= DEPTH);
  a_r6_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r7_pop_needs_entry: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/hlq_log_regs.sv
module hlq_log_regs #(
  parameter int IDXW = 5,
  parameter int HW   = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            wipe,
  input  logic            pfx_en,
  input  logic [IDXW-1:0] ld_idx,
  input  logic            ld_hv,
  input  logic            ld_pp,
  input  logic [HW-1:0]   ld_hdr,
  input  logic [HW-1:0]   ld_pfx,
  output logic [IDXW-1:0] fep,
  output logic            pflag,
  output logic [HW-1:0]   hdr,
  output logic [HW-1:0]   pfx
);
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      fep   <= '0;
      pflag <= 1'b0;
      hdr   <= '0;
      pfx   <= '0;
    end else if (load) begin
      fep <= ld_idx;
      hdr <= ld_hv ? ld_hdr : '0;
      if (ld_pp && pfx_en) begin
        pfx   <= ld_pfx;
        pflag <= 1'b1;
      end else begin
        pfx   <= '0;
        pflag <= 1'b0;
      end
    end
  end

  a_r8_wipe_zeroes: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (fep == '0 && !pflag && hdr == '0 && pfx == '0));
  a_r3_no_header: assert property (@(posedge clk) disable iff (rst)
    (load && !wipe && !ld_hv) |=> hdr == '0);
  a_r4_prefix_gated: assert property (@(posedge clk) disable iff (rst)
    (load && !wipe && !pfx_en) |=> (!pflag && pfx == '0));
endmodule

// File: rtl/hdr_log_queue.sv
module hdr_log_queue #(
  parameter int STAT_W = 32,
  parameter int DW_W   = 32,
  parameter int NDW    = 4,
  parameter int DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        multi_en,
  input  logic                        prefix_en,
  input  logic                        rec_valid,
  input  logic [STAT_W-1:0]           rec_status,
  input  logic                        rec_hdr_valid,
  input  logic                        rec_prefix_present,
  input  logic [NDW*DW_W-1:0]         rec_hdr,
  input  logic [NDW*DW_W-1:0]         rec_prefix,
  input  logic                        clr_valid,
  input  logic [STAT_W-1:0]           clr_mask,
  output logic [STAT_W-1:0]           unc_status,
  output logic [$clog2(STAT_W)-1:0]   first_ptr,
  output logic                        prefix_logged,
  output logic [NDW*DW_W-1:0]         hdr_log,
  output logic [NDW*DW_W-1:0]         prefix_log,
  output logic                        log_overflow,
  output logic                        multi_cap
);
  import hlq_pkg::*;

  localparam int  IDXW  = $clog2(STAT_W);
  localparam int  HW    = NDW * DW_W;
  localparam int  EW    = IDXW + 2 + 2 * HW;
  localparam bit  HAS_Q = (DEPTH > 0);

  logic [STAT_W-1:0] status_q, status_d, nstat, pend;
  logic              ovf_q;
  logic [IDXW-1:0]   rec_idx, fep;
  logic              mhr_on, first_set, full, empty;
  logic [EW-1:0]     rec_ent, head;
  hlq_act_e          act;

  always_comb begin
    rec_idx = '0;
    for (int i = STAT_W - 1; i >= 0; i--)
      if (rec_status[i]) rec_idx = IDXW'(i);
  end

  assign mhr_on    = multi_en && HAS_Q;
  assign first_set = status_q[fep];
  assign nstat     = status_q & ~clr_mask;
  assign rec_ent   = {rec_idx, rec_hdr_valid, rec_prefix_present, rec_hdr, rec_prefix};

  always_comb begin
    act = ACT_IDLE;
    if (rec_valid) begin
      if (mhr_on && first_set) act = full ? ACT_DROP : ACT_QUEUE;
      else                     act = ACT_LOG;
    end else if (clr_valid) begin
      if (!nstat[fep]) act = (mhr_on && !empty) ? ACT_PROMOTE : ACT_WIPE;
      else             act = mhr_on ? ACT_RESTORE : ACT_FLUSH;
    end
  end

  always_comb begin
    case (act)
      ACT_LOG, ACT_QUEUE, ACT_DROP: status_d = status_q | rec_status;
      ACT_PROMOTE, ACT_RESTORE:     status_d = nstat | pend;
      ACT_WIPE, ACT_FLUSH:          status_d = nstat;
      default:                      status_d = status_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      ovf_q    <= (act == ACT_DROP);
    end
  end

  generate
    if (HAS_Q) begin : g_queue
      hlq_entry_fifo #(
        .DEPTH (DEPTH),
        .EW    (EW),
        .IDXW  (IDXW),
        .STAT_W(STAT_W)
      ) i_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (act == ACT_QUEUE),
        .pop      (act == ACT_PROMOTE),
        .flush    ((act == ACT_FLUSH) || (act == ACT_WIPE && !mhr_on)),
        .push_data(rec_ent),
        .push_idx (rec_idx),
        .full     (full),
        .empty    (empty),
        .head     (head),
        .pend     (pend)
      );
    end else begin : g_noqueue
      assign full  = 1'b1;
      assign empty = 1'b1;
      assign head  = '0;
      assign pend  = '0;
    end
  endgenerate

  logic [EW-1:0] ld_ent;
  assign ld_ent = (act == ACT_PROMOTE) ? head : rec_ent;

  hlq_log_regs #(
    .IDXW(IDXW),
    .HW  (HW)
  ) i_log (
    .clk   (clk),
    .rst   (rst),
    .load  ((act == ACT_LOG) || (act == ACT_PROMOTE)),
    .wipe  (act == ACT_WIPE),
    .pfx_en(prefix_en),
    .ld_idx(ld_ent[EW-1 -: IDXW]),
    .ld_hv (ld_ent[2*HW+1]),
    .ld_pp (ld_ent[2*HW]),
    .ld_hdr(ld_ent[2*HW-1 -: HW]),
    .ld_pfx(ld_ent[HW-1:0]),
    .fep   (fep),
    .pflag (prefix_logged),
    .hdr   (hdr_log),
    .pfx   (prefix_log)
  );

  assign unc_status   = status_q;
  assign first_ptr    = fep;
  assign log_overflow = ovf_q;
  assign multi_cap    = HAS_Q;

  a_r2_status_sets: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> (unc_status & $past(rec_status)) == $past(rec_status));
  a_r11_clear_ignored: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> (unc_status & $past(status_q)) == $past(status_q));
  a_r6_pulse_from_request: assert property (@(posedge clk) disable iff (rst)
    log_overflow |-> $past(rec_valid));
  a_r5_queue_keeps_log: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && mhr_on && first_set) |=> ($stable(hdr_log) && $stable(first_ptr)));
endmodule

// File: tb/test_hdr_log_queue.sv
module test_hdr_log_queue;
  localparam int STAT_W = 32;
  localparam int HW     = 128;
  localparam int DEPTH  = 4;
  localparam int VW     = STAT_W + 5 + 1 + 2 * HW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic multi_en = 1'b0, prefix_en = 1'b0;
  logic rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_prefix_present = 1'b0;
  logic [STAT_W-1:0] rec_status = '0, clr_mask = '0;
  logic [HW-1:0] rec_hdr = '0, rec_prefix = '0;
  logic clr_valid = 1'b0;
  logic [STAT_W-1:0] unc_status;
  logic [4:0] first_ptr;
  logic prefix_logged, log_overflow, multi_cap;
  logic [HW-1:0] hdr_log, prefix_log;

  always #5 clk = ~clk;

  hdr_log_queue i_hdr_log_queue (
    .clk(clk), .rst(rst), .multi_en(multi_en), .prefix_en(prefix_en),
    .rec_valid(rec_valid), .rec_status(rec_status), .rec_hdr_valid(rec_hdr_valid),
    .rec_prefix_present(rec_prefix_present), .rec_hdr(rec_hdr), .rec_prefix(rec_prefix),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .unc_status(unc_status),
    .first_ptr(first_ptr), .prefix_logged(prefix_logged), .hdr_log(hdr_log),
    .prefix_log(prefix_log), .log_overflow(log_overflow), .multi_cap(multi_cap)
  );

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [4:0]    idx;
    logic          hv;
    logic          pp;
    logic [HW-1:0] h;
    logic [HW-1:0] p;
  } ent_t;

  logic [STAT_W-1:0] m_stat = '0;
  logic [4:0]        m_fep  = '0;
  logic              m_pf   = 1'b0;
  logic [HW-1:0]     m_hdr  = '0, m_pfx = '0;
  logic              m_ovf  = 1'b0;
  ent_t              m_q[$];

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  function automatic logic [VW-1:0] model_img();
    return {m_stat, m_fep, m_pf, m_hdr, m_pfx, m_ovf};
  endfunction

  task automatic m_load(input ent_t e);
    m_fep = e.idx;
    m_hdr = e.hv ? e.h : '0;
    if (e.pp && prefix_en) begin m_pfx = e.p; m_pf = 1'b1; end
    else begin m_pfx = '0; m_pf = 1'b0; end
  endtask

  task automatic m_wipe();
    m_fep = '0; m_pf = 1'b0; m_hdr = '0; m_pfx = '0;
  endtask

  function automatic logic [STAT_W-1:0] m_pend();
    logic [STAT_W-1:0] r = '0;
    foreach (m_q[k]) r[m_q[k].idx] = 1'b1;
    return r;
  endfunction

  // one request per cycle: drive at falling edge, expect after the rising edge
  task automatic op(input string tag, input bit rv, input int bitn, input bit hv,
                    input bit pp, input bit cv, input logic [STAT_W-1:0] mask);
    ent_t e;
    logic [STAT_W-1:0] ns, pm;
    @(negedge clk);
    e.idx = 5'(bitn); e.hv = hv; e.pp = pp;
    e.h = {4{32'hC0DE_0000 | 32'(bitn)}};
    e.p = {4{32'hBEEF_0000 | 32'(bitn)}};
    rec_valid = rv; rec_status = rv ? (32'd1 << bitn) : '0;
    rec_hdr_valid = hv; rec_prefix_present = pp; rec_hdr = e.h; rec_prefix = e.p;
    clr_valid = cv; clr_mask = mask;
    m_ovf = 1'b0;
    if (rv) begin
      if (multi_en && m_stat[m_fep]) begin
        if (m_q.size() < DEPTH) m_q.push_back(e);
        else m_ovf = 1'b1;
      end else m_load(e);
      m_stat = m_stat | (32'd1 << bitn);
    end else if (cv) begin
      ns = m_stat & ~mask;
      pm = m_pend();
      if (!ns[m_fep]) begin
        if (multi_en && m_q.size() > 0) begin
          m_load(m_q.pop_front());
          m_stat = ns | pm;
        end else begin
          m_wipe();
          if (!multi_en) m_q.delete();
          m_stat = ns;
        end
      end else if (multi_en) m_stat = ns | pm;
      else begin m_q.delete(); m_stat = ns; end
    end
    @(posedge clk);
    #1;
    exp_q.push_back(model_img());
    tag_q.push_back(tag);
  endtask

  // monitor: compares each expected image at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [VW-1:0] act_img, exp_img;
      string t;
      exp_img = exp_q.pop_front();
      t = tag_q.pop_front();
      act_img = {unc_status, first_ptr, prefix_logged, hdr_log, prefix_log, log_overflow};
      checks++;
      if (act_img !== exp_img) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, act_img, exp_img);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_q.push_back('0); tag_q.push_back("R1 reset state");
    @(negedge clk);
    checks++;
    if (multi_cap !== 1'b1) begin
      errors++;
      $display("FAIL R1 multi_cap actual=%b expected=1", multi_cap);
    end

    prefix_en = 1'b1;
    op("R2 R4 log with prefix", 1, 5, 1, 1, 0, '0);
    prefix_en = 1'b0;
    op("R12 R3 R4 overwrite no header no prefix", 1, 9, 0, 1, 0, '0);
    op("R8 clear first with recording off", 0, 0, 0, 0, 1, 32'h0000_0200);
    op("R8 clear remaining bit", 0, 0, 0, 0, 1, 32'h0000_0020);

    multi_en = 1'b1; prefix_en = 1'b1;
    op("R2 R4 first error logged", 1, 3, 1, 1, 0, '0);
    op("R5 queue second", 1, 7, 1, 0, 0, '0);
    op("R5 queue third", 1, 12, 0, 1, 0, '0);
    op("R5 queue fourth", 1, 1, 1, 1, 0, '0);
    op("R5 queue fifth fills", 1, 20, 1, 1, 0, '0);
    op("R6 overflow drop", 1, 25, 1, 1, 0, '0);
    op("R6 pulse ends", 0, 0, 0, 0, 0, '0);
    op("R9 restore queued bit", 0, 0, 0, 0, 1, 32'h0200_1000);
    op("R7 promote oldest", 0, 0, 0, 0, 1, 32'h0000_0008);
    op("R11 record wins over clear", 1, 30, 1, 1, 1, 32'h0000_0080);

    multi_en = 1'b0;
    op("R10 clear flushes queue", 0, 0, 0, 0, 1, 32'h0010_0000);
    multi_en = 1'b1;
    op("R10 R8 no promotion after flush", 0, 0, 0, 0, 1, 32'h0000_0080);
    op("R7 R2 log again after wipe", 1, 2, 1, 1, 0, '0);
    op("R7 idle tail", 0, 0, 0, 0, 0, '0);

    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule